// File: doc/BRIEF.md
# Variable-Granularity TLB Lookup

A small, fully associative address translation buffer. Each entry holds a virtual page number, a physical page number, protection bits and a 2-bit size hint. The hint widens what an entry covers: one 8 KB base page, or an aligned run of 8, 64 or 512 contiguous base pages, up to 4 MB. Every entry accepts all four hint values, so large and small mappings can sit side by side.

A lookup presents a virtual address with a request strobe. Matching is combinational, and the hit, miss, physical address and protection bits are registered and appear on the outputs one cycle later. A separate fill port writes the entry chosen by a round-robin pointer. A single-cycle flush input drops every mapping and returns the pointer to entry 0. Table walks and miss handling are left to the surrounding logic, which sees only the miss flag.

Top module: `vg_tlb`

## Requirements
- R1: After reset no entry is valid, the fill pointer is 0, and lk_hit and lk_miss are 0 until a lookup is requested; a lookup that follows reset misses.
- R2: On a hit, lk_pa[12:0] equals lk_va[12:0] of the lookup.
- R3: Hint value g (0,1,2,3) makes an entry span 1, 8, 64 or 512 base pages: the low 3*g bits of the virtual page number (lk_va[31:13]) are left out of the compare, and every other bit must match.
- R4: On a hit, lk_pa[31:13] takes the stored physical page number in its upper bits and the low 3*g bits of the lookup's virtual page number.
- R5: A fill clears the low 3*g bits of the stored virtual and physical page numbers, whatever values the fill port carries there.
- R6: When several valid entries match, the one with the lowest index supplies the result.
- R7: Fills write entries 0, 1, ..., ENTRIES-1 in turn and then wrap to 0; the entry written is replaced in full.
- R8: Flush clears every valid bit and resets the fill pointer to 0 in one cycle; a fill in the same cycle is dropped.
- R9: Results appear on the outputs one cycle after the lookup is requested, and a lookup sees the table as it was before any fill or flush in the same cycle.
- R10: lk_miss is 1 exactly when a lookup was requested and no valid entry matched; with no request both flags are 0; when lk_hit is 0, lk_pa and lk_prot are 0.
- R11: On a hit, lk_prot is the protection value written with the winning entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W (32) | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_miss | output | 1 | Registered miss flag |
| lk_pa | output | PA_W (32) | Registered physical address |
| lk_prot | output | PROT_W (4) | Registered protection bits |
| fill_en | input | 1 | Write one entry |
| fill_vpn | input | VA_W-13 | Virtual page number to store |
| fill_ppn | input | PA_W-13 | Physical page number to store |
| fill_gh | input | 2 | Size hint of the new entry |
| fill_prot | input | PROT_W | Protection bits of the new entry |
| inval_all | input | 1 | Flush all entries |

## Verification
Directed addresses sit on the edges of a large mapping (last covered page and the first page past it), which separates a correct mask width from one that is off by a hint step. Deliberately overlapping entries of different sizes separate lowest-index priority from any other pick, and fills with junk in the masked bits show whether those bits leak into the match or the physical address. Random traffic then draws page numbers from a few narrow regions with random hints, so hits, misses, overlaps and pointer wrap happen often and are scored against a bench model of the table.

// File: rtl/vg_tlb.sv
module vg_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 8,
  parameter int PROT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_req,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic [PA_W-1:0]       lk_pa,
  output logic [PROT_W-1:0]     lk_prot,
  input  logic                  fill_en,
  input  logic [VA_W-14:0]      fill_vpn,
  input  logic [PA_W-14:0]      fill_ppn,
  input  logic [1:0]            fill_gh,
  input  logic [PROT_W-1:0]     fill_prot,
  input  logic                  inval_all
);
  localparam int OFS   = 13;
  localparam int VPN_W = VA_W - OFS;
  localparam int PPN_W = PA_W - OFS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [8:0] low_bits(input logic [1:0] g);
    case (g)
      2'd0: low_bits = 9'h000;
      2'd1: low_bits = 9'h007;
      2'd2: low_bits = 9'h03f;
      default: low_bits = 9'h1ff;
    endcase
  endfunction

  logic [ENTRIES-1:0] e_v;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [1:0]         e_g    [ENTRIES];
  logic [PROT_W-1:0]  e_prot [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  logic [VPN_W-1:0]   va_vpn;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;
  logic               hit_c;
  logic [PA_W-1:0]    pa_c;

  assign va_vpn = lk_va[VA_W-1:OFS];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = e_v[i] &&
      ((va_vpn & ~VPN_W'(low_bits(e_g[i]))) == e_vpn[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  assign hit_c = |match;
  assign pa_c  = {e_ppn[sel] | (PPN_W'(va_vpn[8:0]) & PPN_W'(low_bits(e_g[sel]))),
                  lk_va[OFS-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0;
      ptr <= '0;
    end else if (inval_all) begin
      e_v <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      e_v[ptr]    <= 1'b1;
      e_vpn[ptr]  <= fill_vpn & ~VPN_W'(low_bits(fill_gh));
      e_ppn[ptr]  <= fill_ppn & ~PPN_W'(low_bits(fill_gh));
      e_g[ptr]    <= fill_gh;
      e_prot[ptr] <= fill_prot;
      ptr         <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_pa   <= '0;
      lk_prot <= '0;
    end else begin
      lk_hit  <= lk_req && hit_c;
      lk_miss <= lk_req && !hit_c;
      lk_pa   <= (lk_req && hit_c) ? pa_c : '0;
      lk_prot <= (lk_req && hit_c) ? e_prot[sel] : '0;
    end
  end
endmodule

// File: rtl/vg_tlb_chk.sv
module vg_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic            inval_all,
  input logic            lk_hit,
  input logic            lk_miss,
  input logic [PA_W-1:0] lk_pa
);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  assert_req_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (lk_hit != lk_miss));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_hit && !lk_miss));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (!lk_hit || lk_pa[12:0] == $past(lk_va[12:0])));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all ##1 1'b1 |=> !lk_hit);
endmodule

bind vg_tlb vg_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
  .inval_all(inval_all), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa)
);

// File: tb/sim_vg_tlb.sv
`timescale 1ns/1ps
module sim_vg_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pa;
  logic [3:0]  lk_prot;
  logic        fill_en = 1'b0;
  logic [18:0] fill_vpn = '0;
  logic [18:0] fill_ppn = '0;
  logic [1:0]  fill_gh = '0;
  logic [3:0]  fill_prot = '0;
  logic        inval_all = 1'b0;

  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  vg_tlb #(.VA_W(32), .PA_W(32), .ENTRIES(N), .PROT_W(4)) u0 (.*);

  logic        m_v [N];
  logic [18:0] m_vpn [N];
  logic [18:0] m_ppn [N];
  logic [1:0]  m_g [N];
  logic [3:0]  m_prot [N];
  int          m_ptr;

  function automatic logic [18:0] lowm(input logic [1:0] g);
    return 19'((1 << (3 * g)) - 1);
  endfunction

  logic        x_hit, x_miss;
  logic [31:0] x_pa;
  logic [3:0]  x_prot;

  task automatic predict();
    int w = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && ((lk_va[31:13] & ~lowm(m_g[i])) == m_vpn[i])) w = i;
    x_hit = lk_req && (w >= 0);
    x_miss = lk_req && (w < 0);
    x_pa = '0; x_prot = '0;
    if (x_hit) begin
      x_pa = {m_ppn[w] | (lk_va[31:13] & lowm(m_g[w])), lk_va[12:0]};
      x_prot = m_prot[w];
    end
  endtask

  task automatic model_update();
    if (inval_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_ptr = 0;
    end else if (fill_en) begin
      m_v[m_ptr] = 1'b1;
      m_vpn[m_ptr] = fill_vpn & ~lowm(fill_gh);
      m_ppn[m_ptr] = fill_ppn & ~lowm(fill_gh);
      m_g[m_ptr] = fill_gh;
      m_prot[m_ptr] = fill_prot;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    model_update();
    @(negedge clk);
    vectors++;
    if (lk_hit !== x_hit || lk_miss !== x_miss || lk_pa !== x_pa || lk_prot !== x_prot) begin
      errors++;
      $display("FAIL %s: got hit=%b miss=%b pa=%h prot=%h, want hit=%b miss=%b pa=%h prot=%h",
               tag, lk_hit, lk_miss, lk_pa, lk_prot, x_hit, x_miss, x_pa, x_prot);
    end
    lk_req = 1'b0; fill_en = 1'b0; inval_all = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    lk_req = 1'b1; lk_va = va; step(tag);
  endtask

  task automatic fill(input logic [18:0] v, input logic [18:0] p, input logic [1:0] g,
                      input logic [3:0] pr);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_gh = g; fill_prot = pr;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    look(32'h1234_5678, "R1");

    fill(19'h00100, 19'h40000, 2'd0, 4'h5); step("R7");
    look({19'h00100, 13'h0abc}, "R2");
    look({19'h00101, 13'h0abc}, "R3");

    fill(19'h02000 | 19'h1ff, 19'h10000 | 19'h0ab, 2'd3, 4'h9); step("R5");
    look({19'h021ff, 13'h1fff}, "R4");
    look({19'h02200, 13'h0000}, "R3");
    look({19'h02000, 13'h0001}, "R5");

    fill(19'h00100, 19'h50000, 2'd1, 4'h3); step("R7");
    look({19'h00100, 13'h0010}, "R6");
    look({19'h00103, 13'h0010}, "R11");

    lk_req = 1'b1; lk_va = {19'h03000, 13'h0}; fill(19'h03000, 19'h1, 2'd0, 4'h1); step("R9");
    look({19'h03000, 13'h0}, "R9");

    inval_all = 1'b1; fill(19'h04000, 19'h2, 2'd0, 4'h2); step("R8");
    look({19'h04000, 13'h0}, "R8");
    look({19'h00100, 13'h0}, "R8");

    for (int i = 0; i <= N; i++) begin
      fill(19'h05000 + 19'(i), 19'h7000 + 19'(i), 2'd0, 4'(i)); step("R7");
    end
    look({19'h05000, 13'h0}, "R7");
    look({19'h05001, 13'h0}, "R7");
    look({19'h05008, 13'h0}, "R7");

    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 15) fill(19'((($urandom % 4) << 10) | ($urandom & 32'h3ff)),
                       19'($urandom), 2'($urandom), 4'($urandom));
      if (r == 99) inval_all = 1'b1;
      if (r % 3 != 0) begin
        lk_req = 1'b1;
        lk_va = {19'((($urandom % 4) << 10) | ($urandom & 32'h3ff)), 13'($urandom)};
      end
      step("R3/R4/R6/R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule